// File: doc/BRIEF.md
# Palette Colour-Map Register Interface

The block holds the colour map of a pseudocolour display: 256 normal entries and 4 overlay entries. Each entry carries three 8-bit components: red, green and blue. Software reaches the map through a 32-bit register bus that accepts word accesses only.

Software first loads a colour index. It then writes or reads the components one at a time, always in red, green, blue order. A single phase counter is shared by reads and writes. After the blue component the phase returns to red and the index moves on by one, wrapping modulo 256. A separate write offset reaches the overlay entries, selected by the low two bits of the index.

The scan-out logic uses a second port that is read-only. It turns an 8-bit pixel value into a 24-bit colour one clock later. Overlay entries 2 and 3 are presented at all times to the cursor logic.

Top module: `palette_dac`

## Requirements
- R1: After reset, the index and the phase are 0 (red). Every component of every entry is 0, except normal entry 255 and overlay entries 0 and 2, which are white (0xFF in each of the three components).
- R2: A word write at byte offset 0x0 loads the index from data bits 31:24 and returns the phase to red.
- R3: A word write at offset 0x4 stores data bits 31:24 into the component of normal entry [index] that the phase selects. The phase steps red, green, blue, red. When blue is written the index increments and wraps from 255 to 0.
- R4: A word write at offset 0xC stores data bits 31:24 into overlay entry (index mod 4). It uses the same phase stepping and the same index increment after blue, and leaves the normal entries unchanged.
- R5: A word read at any offset returns, one clock after the access, the phase-selected component of normal entry [index] in bits 31:24, with bits 23:0 zero. It then steps the phase and the index exactly as a write does.
- R6: Reads and writes advance one common phase. For example, a write of red, then a read, then a write gives the red write, a read of green and a write of blue.
- R7: A word write at any offset other than 0x0, 0x4 and 0xC changes no entry, no index and no phase.
- R8: An access whose size code is not word is ignored: no entry, index, phase or read data changes. Size codes are 0 = byte, 1 = halfword, 2 = word.
- R9: The lookup output gives {R,G,B} (red in bits 23:16) of normal entry lut_idx as it stood before the previous clock edge, with one clock of latency. A bus write in that same cycle becomes visible on the following cycle.
- R10: cursor_col0 and cursor_col1 show overlay entries 2 and 3 as {R,G,B}. They change only after an overlay write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| lut_idx | input | 8 | Pixel value to look up |
| lut_rgb | output | 24 | Colour of lut_idx, one clock later |
| cursor_col0 | output | 24 | Overlay entry 2 {R,G,B} |
| cursor_col1 | output | 24 | Overlay entry 3 {R,G,B} |

## Verification
A bus component write and a lookup of the same entry can fall in the same cycle. The bench provokes this on purpose: it drives the blue write to entry 10 while lut_idx is 10. It expects the old blue in that cycle's lookup result and the new blue one cycle later. Random mixes of index loads, component writes, overlay writes, reads, stray offsets and narrow accesses are scored against a bench model of the phase and index. Each read result is checked against the model, and lookups are spread throughout.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int BUS_W  = 32;
  localparam int COMP_W = 8;
  localparam int NCOMP  = 3;

  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [3:0] OFF_INDEX = 4'h0;
  localparam logic [3:0] OFF_NORM  = 4'h4;
  localparam logic [3:0] OFF_OVL   = 4'hC;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [COMP_W-1:0] top_byte(logic [BUS_W-1:0] d);
    return d[BUS_W-1 -: COMP_W];
  endfunction

  function automatic logic [BUS_W-1:0] place_byte(logic [COMP_W-1:0] c);
    return {c, {(BUS_W-COMP_W){1'b0}}};
  endfunction
endpackage

// File: rtl/dac_seq.sv
module dac_seq
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [COMP_W-1:0] acc_byte,
  output logic [IDX_W-1:0]  idx_q,
  output phase_t            phase_q,
  output logic              wr_norm,
  output logic              wr_ovl,
  output logic              rd_step
);
  logic acc_word, idx_load, step_ev, blue_done, stray_wr;

  assign acc_word  = acc_sel && (acc_size == SIZE_WORD);
  assign idx_load  = acc_word && acc_we && (acc_addr == ADDR_W'(OFF_INDEX));
  assign wr_norm   = acc_word && acc_we && (acc_addr == ADDR_W'(OFF_NORM));
  assign wr_ovl    = acc_word && acc_we && (acc_addr == ADDR_W'(OFF_OVL));
  assign rd_step   = acc_word && !acc_we;
  assign step_ev   = wr_norm || wr_ovl || rd_step;
  assign blue_done = step_ev && (phase_q == PH_BLU);
  assign stray_wr  = acc_word && acc_we && !idx_load && !wr_norm && !wr_ovl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (idx_load) begin
      idx_q   <= IDX_W'(acc_byte);
      phase_q <= PH_RED;
    end else if (step_ev) begin
      phase_q <= phase_after(phase_q);
      if (blue_done) idx_q <= idx_q + 1'b1;
    end
  end

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (idx_q == $past(IDX_W'(acc_byte))) && (phase_q == PH_RED));

  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blue_done |=> (idx_q == $past(idx_q) + 1'b1) && (phase_q == PH_RED));

  assert_stray_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> $stable(idx_q) && $stable(phase_q));

  assert_narrow_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && acc_size != SIZE_WORD) |=> $stable(idx_q) && $stable(phase_q));
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int OVL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_norm,
  input  logic                    wr_ovl,
  input  logic [IDX_W-1:0]        idx,
  input  phase_t                  phase,
  input  logic [COMP_W-1:0]       wbyte,
  output logic [COMP_W-1:0]       rd_comp,
  input  logic [IDX_W-1:0]        lut_idx,
  output logic [NCOMP*COMP_W-1:0] lut_rgb,
  output logic [NCOMP*COMP_W-1:0] cur_col0,
  output logic [NCOMP*COMP_W-1:0] cur_col1
);
  localparam int NORM_N = 1 << IDX_W;
  localparam int OVL_N  = 1 << OVL_W;
  localparam int CUR0   = 2;
  localparam int CUR1   = 3;

  logic [COMP_W-1:0] norm_mem [NCOMP][NORM_N];
  logic [COMP_W-1:0] ovl_mem  [NCOMP][OVL_N];
  logic [OVL_W-1:0]  slot;

  assign slot = idx[OVL_W-1:0];

  function automatic logic ovl_white(int s);
    return (s == 0) || (s == 2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOMP; c++) begin
        for (int i = 0; i < NORM_N; i++)
          norm_mem[c][i] <= (i == NORM_N - 1) ? '1 : '0;
        for (int s = 0; s < OVL_N; s++)
          ovl_mem[c][s] <= ovl_white(s) ? '1 : '0;
      end
    end else begin
      if (wr_norm) norm_mem[phase][idx] <= wbyte;
      if (wr_ovl)  ovl_mem[phase][slot] <= wbyte;
    end
  end

  assign rd_comp = norm_mem[phase][idx];

  always_ff @(posedge clk) begin
    if (!rst_n) lut_rgb <= '0;
    else        lut_rgb <= {norm_mem[0][lut_idx], norm_mem[1][lut_idx], norm_mem[2][lut_idx]};
  end

  assign cur_col0 = {ovl_mem[0][CUR0], ovl_mem[1][CUR0], ovl_mem[2][CUR0]};
  assign cur_col1 = {ovl_mem[0][CUR1], ovl_mem[1][CUR1], ovl_mem[2][CUR1]};

  assert_cursor_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovl |=> $stable(cur_col0) && $stable(cur_col1));
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_W  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [1:0]              bus_size,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [IDX_W-1:0]        lut_idx,
  output logic [NCOMP*COMP_W-1:0] lut_rgb,
  output logic [NCOMP*COMP_W-1:0] cursor_col0,
  output logic [NCOMP*COMP_W-1:0] cursor_col1
);
  logic [IDX_W-1:0]  idx_q;
  phase_t            phase_q;
  logic              wr_norm, wr_ovl, rd_step;
  logic [COMP_W-1:0] wbyte, rd_comp;
  logic              unused_low;

  assign wbyte      = top_byte(bus_wdata);
  assign unused_low = ^bus_wdata[BUS_W-COMP_W-1:0];

  dac_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_sel(bus_sel), .acc_we(bus_we), .acc_addr(bus_addr),
    .acc_size(bus_size), .acc_byte(wbyte),
    .idx_q(idx_q), .phase_q(phase_q),
    .wr_norm(wr_norm), .wr_ovl(wr_ovl), .rd_step(rd_step)
  );

  palette_store #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_norm(wr_norm), .wr_ovl(wr_ovl),
    .idx(idx_q), .phase(phase_q), .wbyte(wbyte), .rd_comp(rd_comp),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb),
    .cur_col0(cursor_col0), .cur_col1(cursor_col1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (rd_step) bus_rdata <= place_byte(rd_comp);
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_step |=> $stable(bus_rdata));

  assert_rdata_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> bus_rdata[BUS_W-COMP_W-1:0] == '0);
endmodule

// File: tb/palette_dac_test.sv
`timescale 1ns/1ps
module palette_dac_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [1:0]  bus_size = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_idx = 0;
  logic [23:0] lut_rgb, cursor_col0, cursor_col1;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  ref_c [3][260];
  int          ref_idx, ref_ph;
  logic [31:0] ref_rdata;

  always #2 clk = ~clk;

  palette_dac uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
    .cursor_col0(cursor_col0), .cursor_col1(cursor_col1)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_rgb(int e);
    return {ref_c[0][e], ref_c[1][e], ref_c[2][e]};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 260; e++)
        ref_c[c][e] = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
    ref_idx = 0; ref_ph = 0; ref_rdata = 0;
  endtask

  task automatic model_adv();
    if (ref_ph == 2) begin ref_ph = 0; ref_idx = (ref_idx + 1) % 256; end
    else ref_ph++;
  endtask

  task automatic model_access(bit we, logic [3:0] a, logic [31:0] d, logic [1:0] sz);
    if (sz != 2'd2) return;
    if (we) begin
      if (a == 4'h0) begin ref_idx = d[31:24]; ref_ph = 0; end
      else if (a == 4'h4) begin ref_c[ref_ph][ref_idx] = d[31:24]; model_adv(); end
      else if (a == 4'hC) begin ref_c[ref_ph][256 + (ref_idx % 4)] = d[31:24]; model_adv(); end
    end else begin
      ref_rdata = {ref_c[ref_ph][ref_idx], 24'h0};
      model_adv();
    end
  endtask

  task automatic bus_op(bit we, logic [3:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 0;
    model_access(we, a, d, sz);
  endtask

  task automatic lut_chk(string tag, logic [7:0] i);
    @(negedge clk);
    lut_idx = i;
    @(negedge clk);
    chk(tag, {8'h0, lut_rgb}, {8'h0, ref_rgb(i)});
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state at the ports
    @(negedge clk);
    chk("R1 cursor_col0", {8'h0, cursor_col0}, 32'h00FFFFFF);
    chk("R1 cursor_col1", {8'h0, cursor_col1}, 32'h0);
    lut_chk("R1 entry 255", 8'd255);
    lut_chk("R1 entry 0", 8'd0);
    bus_op(0, 4'h0, 0, 2'd2);
    chk("R1 R5 read red of 0", bus_rdata, ref_rdata);
    bus_op(0, 4'h4, 0, 2'd2);
    bus_op(0, 4'h8, 0, 2'd2);
    bus_op(0, 4'h0, 0, 2'd2);
    chk("R1 R5 read red of 1", bus_rdata, 32'h0);

    // R2 R3 R6: shared phase and index wrap
    bus_op(1, 4'h0, 32'hFF00_0000, 2'd2);
    bus_op(1, 4'h4, 32'hA1FF_FFFF, 2'd2);
    bus_op(0, 4'h4, 0, 2'd2);
    chk("R6 read green after red write", bus_rdata, 32'hFF00_0000);
    bus_op(1, 4'h4, 32'hB200_0000, 2'd2);
    lut_chk("R3 entry 255 rewritten", 8'd255);
    bus_op(0, 4'h0, 0, 2'd2);
    chk("R3 index wrapped to 0", bus_rdata, 32'h0);
    chk("R3 wrap model", {24'h0, 8'(ref_idx)}, 32'h0);

    // R4 R10: overlay writes via index 6 (slot 2)
    bus_op(1, 4'h0, 32'h0600_0000, 2'd2);
    bus_op(1, 4'hC, 32'h1200_0000, 2'd2);
    bus_op(1, 4'hC, 32'h3400_0000, 2'd2);
    bus_op(1, 4'hC, 32'h5600_0000, 2'd2);
    chk("R10 R4 cursor_col0", {8'h0, cursor_col0}, 32'h0012_3456);
    lut_chk("R4 normal entry 6 untouched", 8'd6);
    bus_op(1, 4'h0, 32'h0700_0000, 2'd2);
    bus_op(1, 4'hC, 32'h0100_0000, 2'd2);
    bus_op(1, 4'hC, 32'h0200_0000, 2'd2);
    bus_op(1, 4'hC, 32'h0300_0000, 2'd2);
    chk("R10 cursor_col1", {8'h0, cursor_col1}, 32'h0001_0203);
    bus_op(0, 4'h0, 0, 2'd2);
    chk("R4 index advanced to 8", bus_rdata, ref_rdata);

    // R7 R8: stray offset and narrow access
    bus_op(1, 4'h0, 32'h0A00_0000, 2'd2);
    bus_op(1, 4'h8, 32'hEE00_0000, 2'd2);
    bus_op(1, 4'h4, 32'hEE00_0000, 2'd0);
    bus_op(0, 4'h4, 0, 2'd1);
    chk("R8 narrow read holds rdata", bus_rdata, ref_rdata);
    lut_chk("R7 R8 entry 10 unchanged", 8'd10);

    // R9: write and lookup of the same entry in one cycle
    bus_op(1, 4'h4, 32'h1100_0000, 2'd2);
    bus_op(1, 4'h4, 32'h2200_0000, 2'd2);
    @(negedge clk);
    lut_idx = 8'd10;
    bus_sel = 1; bus_we = 1; bus_addr = 4'h4; bus_wdata = 32'h3300_0000; bus_size = 2'd2;
    @(negedge clk);
    bus_sel = 0;
    chk("R9 same-cycle lookup sees old", {8'h0, lut_rgb}, {8'h0, ref_rgb(10)});
    model_access(1, 4'h4, 32'h3300_0000, 2'd2);
    @(negedge clk);
    chk("R9 next-cycle lookup sees new", {8'h0, lut_rgb}, 32'h0011_2233);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 16;
      d = $urandom;
      if (r < 2)       bus_op(1, 4'h0, d, 2'd2);
      else if (r < 7)  bus_op(1, 4'h4, d, 2'd2);
      else if (r < 9)  bus_op(1, 4'hC, d, 2'd2);
      else if (r < 13) bus_op(0, 4'($urandom), d, 2'd2);
      else if (r == 13) bus_op(1, 4'h8, d, 2'd2);
      else if (r == 14) bus_op($urandom % 2 == 1, 4'h4, d, 2'($urandom % 2));
      else             bus_op(1, 4'($urandom % 4 + 1), d, 2'd2);
      chk("R5 R6 R7 R8 random rdata", bus_rdata, ref_rdata);
      if (n % 8 == 0) lut_chk("R9 random lookup", 8'($urandom));
      chk("R10 random cursor0", {8'h0, cursor_col0}, {8'h0, ref_rgb(258)});
      chk("R10 random cursor1", {8'h0, cursor_col1}, {8'h0, ref_rgb(259)});
    end

    for (int i = 0; i < 256; i++) lut_chk("R9 sweep", 8'(i));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule